// File: doc/BRIEF.md
# Dual-Channel Upset-Tolerant Output Combiner

This block sits behind two identical two-stage pipelined successive-approximation converters that sample the same analog input. Each converter hands over a coarse first-stage code and a fine second-stage code. The block builds one word per channel from these codes. It then looks for evidence that a single-event upset disturbed either channel. Two kinds of evidence count: an external hit pulse seen during the sample period, and a second-stage code pinned at either rail, which shows the first stage went out of range.

When `sample_i` pulses, the block produces one output word. If neither channel carries evidence and the two words are close, the output is their mean, with one fractional bit kept. If exactly one channel carries evidence, the output is the other channel's word. If both channels carry evidence, or the words disagree beyond the programmable threshold with no evidence on either, the output falls back to channel A and raises an uncorrectable flag. A saturating counter tallies the samples that showed any kind of disturbance.

Top module: `see_dual_combiner`

## Requirements
- R1: Each channel word equals first-stage code × 2^SHIFT plus second-stage code. With the defaults (9-bit and 7-bit codes, SHIFT=4) this word is 14 bits wide and reaches at most 8303.
- R2: A channel is flagged in a sample when its second-stage code is all zeros or all ones.
- R3: A channel is flagged when its hit input was high in any cycle since the previous strobe, counting the strobe cycle itself. The hit memory is cleared after each strobe, so a hit does not carry into the next sample.
- R4: When neither channel is flagged and |A−B| ≤ threshold, `out_word_o` = A+B, read as the mean with one fractional bit (LSB weight ½), and `sel_o` = 2'b00.
- R5: When exactly one channel is flagged, `out_word_o` = 2 × (unflagged word), `sel_o` names that channel (2'b01 = A, 2'b10 = B), and `uncorr_o` = 0.
- R6: When both channels are flagged, or when neither is flagged and |A−B| > threshold, `out_word_o` = 2 × A, `sel_o` = 2'b01 and `uncorr_o` = 1.
- R7: The threshold resets to 8. A cycle with `thr_we_i` high loads `thr_i`. Only a difference strictly above the threshold counts as disagreement.
- R8: The outputs are registered. `out_valid_o` is high for exactly the one cycle after a strobe cycle. `out_word_o`, `sel_o`, `uncorr_o` and `flags_o` (bit 0 = A, bit 1 = B) hold their values between strobes.
- R9: `err_cnt_o` increments once for every strobed sample that has any flag or a disagreement, and it stops at its maximum value.
- R10: Under reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | End-of-period strobe; the codes are valid in this cycle |
| a_s1_i | input | S1_W | Channel A first-stage code |
| a_s2_i | input | S2_W | Channel A second-stage code |
| b_s1_i | input | S1_W | Channel B first-stage code |
| b_s2_i | input | S2_W | Channel B second-stage code |
| a_hit_i | input | 1 | Channel A summing-node hit pulse |
| b_hit_i | input | 1 | Channel B summing-node hit pulse |
| thr_we_i | input | 1 | Threshold write enable |
| thr_i | input | WORD_W | Threshold write value |
| out_valid_o | output | 1 | Result valid, one cycle after the strobe |
| out_word_o | output | WORD_W+1 | Combined word, one fractional bit |
| sel_o | output | 2 | Source: 00 mean, 01 A, 10 B |
| uncorr_o | output | 1 | Uncorrectable sample |
| flags_o | output | 2 | Per-channel upset evidence for the sample |
| err_cnt_o | output | CNT_W | Saturating count of disturbed samples |

## Verification
The bench keeps the default code widths and shift, so full-scale codes exercise the widest assembled word and the widest mean. It builds the block with CNT_W=3, which brings counter saturation within reach after seven disturbed samples. The threshold is rewritten during the run, so both the default value and a loaded value are tested exactly at the boundary and one LSB above it.

// File: rtl/see_comb_pkg.sv
package see_comb_pkg;
  typedef enum logic [1:0] {
    SRC_MEAN = 2'b00,
    SRC_A    = 2'b01,
    SRC_B    = 2'b10
  } src_e;
endpackage

// File: rtl/see_chan_front.sv
module see_chan_front #(
  parameter int S1_W   = 9,
  parameter int S2_W   = 7,
  parameter int SHIFT  = 4,
  parameter int WORD_W = S1_W + SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_end_i,
  input  logic              hit_i,
  input  logic [S1_W-1:0]   s1_i,
  input  logic [S2_W-1:0]   s2_i,
  output logic [WORD_W-1:0] word_o,
  output logic              flag_o
);
  logic hit_q, hit_d;
  logic rail;

  // Sticky hit memory: cleared after the strobe, set by any pulse in the period.
  always_comb begin
    if (period_end_i) hit_d = 1'b0;
    else              hit_d = hit_q | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  // A fine code pinned at a rail shows the coarse stage left its range.
  assign rail   = (&s2_i) | ~(|s2_i);
  assign word_o = (WORD_W'(s1_i) << SHIFT) + WORD_W'(s2_i);
  assign flag_o = hit_q | hit_i | rail;

  a_r3_hit_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    period_end_i |=> !hit_q);
  a_r3_hit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q || hit_i) && !period_end_i |=> hit_q);
endmodule

// File: rtl/see_fuse_decide.sv
module see_fuse_decide
  import see_comb_pkg::*;
#(
  parameter int WORD_W = 14,
  parameter int OUT_W  = WORD_W + 1
) (
  input  logic [WORD_W-1:0] word_a_i,
  input  logic [WORD_W-1:0] word_b_i,
  input  logic              flag_a_i,
  input  logic              flag_b_i,
  input  logic [WORD_W-1:0] thr_i,
  output logic [OUT_W-1:0]  out_word_o,
  output src_e              src_o,
  output logic              uncorr_o,
  output logic              event_o
);
  logic [WORD_W-1:0] mag;
  logic              big;
  logic [OUT_W-1:0]  mean_w, a_w, b_w;

  always_comb begin
    if (word_a_i >= word_b_i) mag = word_a_i - word_b_i;
    else                      mag = word_b_i - word_a_i;
  end

  assign big    = mag > thr_i;
  assign mean_w = OUT_W'(word_a_i) + OUT_W'(word_b_i);
  assign a_w    = {word_a_i, 1'b0};
  assign b_w    = {word_b_i, 1'b0};

  always_comb begin
    out_word_o = a_w;
    src_o      = SRC_A;
    uncorr_o   = 1'b0;
    unique case ({flag_a_i, flag_b_i})
      2'b00: begin
        if (big) uncorr_o = 1'b1;
        else begin
          out_word_o = mean_w;
          src_o      = SRC_MEAN;
        end
      end
      2'b10: begin
        out_word_o = b_w;
        src_o      = SRC_B;
      end
      2'b01: ;
      default: uncorr_o = 1'b1;
    endcase
  end

  assign event_o = flag_a_i | flag_b_i | big;
endmodule

// File: rtl/see_err_tally.sv
module see_err_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i && inc_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  a_r9_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);
  a_r9_no_step_back: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q >= $past(cnt_q));
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i && inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/see_dual_combiner.sv
module see_dual_combiner
  import see_comb_pkg::*;
#(
  parameter int S1_W    = 9,
  parameter int S2_W    = 7,
  parameter int SHIFT   = 4,
  parameter int CNT_W   = 16,
  parameter int THR_DEF = 8,
  localparam int WORD_W = S1_W + SHIFT + 1,
  localparam int OUT_W  = WORD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic [S1_W-1:0]   a_s1_i,
  input  logic [S2_W-1:0]   a_s2_i,
  input  logic [S1_W-1:0]   b_s1_i,
  input  logic [S2_W-1:0]   b_s2_i,
  input  logic              a_hit_i,
  input  logic              b_hit_i,
  input  logic              thr_we_i,
  input  logic [WORD_W-1:0] thr_i,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  out_word_o,
  output logic [1:0]        sel_o,
  output logic              uncorr_o,
  output logic [1:0]        flags_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  localparam int NCH = 2;

  logic [S1_W-1:0]   s1_v  [NCH];
  logic [S2_W-1:0]   s2_v  [NCH];
  logic [NCH-1:0]    hit_v;
  logic [WORD_W-1:0] word_v [NCH];
  logic [NCH-1:0]    flag_v;

  assign s1_v[0] = a_s1_i;
  assign s2_v[0] = a_s2_i;
  assign s1_v[1] = b_s1_i;
  assign s2_v[1] = b_s2_i;
  assign hit_v   = {b_hit_i, a_hit_i};

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    see_chan_front #(
      .S1_W(S1_W), .S2_W(S2_W), .SHIFT(SHIFT), .WORD_W(WORD_W)
    ) i_front (
      .clk(clk), .rst_n(rst_n), .period_end_i(sample_i),
      .hit_i(hit_v[c]), .s1_i(s1_v[c]), .s2_i(s2_v[c]),
      .word_o(word_v[c]), .flag_o(flag_v[c])
    );
  end

  // Threshold register
  logic [WORD_W-1:0] thr_q, thr_d;
  always_comb begin
    thr_d = thr_q;
    if (thr_we_i) thr_d = thr_i;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= WORD_W'(THR_DEF);
    else        thr_q <= thr_d;
  end

  logic [OUT_W-1:0] dec_word;
  src_e             dec_src;
  logic             dec_unc, dec_evt;

  see_fuse_decide #(.WORD_W(WORD_W), .OUT_W(OUT_W)) i_decide (
    .word_a_i(word_v[0]), .word_b_i(word_v[1]),
    .flag_a_i(flag_v[0]), .flag_b_i(flag_v[1]),
    .thr_i(thr_q),
    .out_word_o(dec_word), .src_o(dec_src),
    .uncorr_o(dec_unc), .event_o(dec_evt)
  );

  see_err_tally #(.CNT_W(CNT_W)) i_tally (
    .clk(clk), .rst_n(rst_n), .en_i(sample_i), .inc_i(dec_evt),
    .cnt_o(err_cnt_o)
  );

  // Output registers, loaded only on the strobe
  logic [OUT_W-1:0] word_q, word_d;
  logic [1:0]       sel_q, sel_d, flg_q, flg_d;
  logic             unc_q, unc_d, vld_q;

  always_comb begin
    word_d = word_q;
    sel_d  = sel_q;
    flg_d  = flg_q;
    unc_d  = unc_q;
    if (sample_i) begin
      word_d = dec_word;
      sel_d  = dec_src;
      flg_d  = flag_v;
      unc_d  = dec_unc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      sel_q  <= '0;
      flg_q  <= '0;
      unc_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      sel_q  <= sel_d;
      flg_q  <= flg_d;
      unc_q  <= unc_d;
      vld_q  <= sample_i;
    end
  end

  assign out_valid_o = vld_q;
  assign out_word_o  = word_q;
  assign sel_o       = sel_q;
  assign uncorr_o    = unc_q;
  assign flags_o     = flg_q;

  a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i |=> out_valid_o);
  a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> !out_valid_o);
  a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> $stable(out_word_o) && $stable(sel_o));
  a_r4_mean_unflagged: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && sel_o == 2'b00 |-> flags_o == 2'b00 && !uncorr_o);
  a_r6_fallback_is_a: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && uncorr_o |-> sel_o == 2'b01 && !out_word_o[0]);
  a_r5_pick_unflagged: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && $onehot(flags_o) |-> !uncorr_o && (sel_o & flags_o) == 2'b00);
endmodule

// File: tb/test_see_dual_combiner.sv
module test_see_dual_combiner;
  localparam int S1_W = 9, S2_W = 7, SHIFT = 4, CNT_W = 3;
  localparam int WORD_W = S1_W + SHIFT + 1, OUT_W = WORD_W + 1;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sample_i = 1'b0, a_hit_i = 1'b0, b_hit_i = 1'b0, thr_we_i = 1'b0;
  logic [S1_W-1:0] a_s1_i = '0, b_s1_i = '0;
  logic [S2_W-1:0] a_s2_i = '0, b_s2_i = '0;
  logic [WORD_W-1:0] thr_i = '0;
  logic out_valid_o, uncorr_o;
  logic [OUT_W-1:0] out_word_o;
  logic [1:0] sel_o, flags_o;
  logic [CNT_W-1:0] err_cnt_o;

  always #4 clk = ~clk;

  see_dual_combiner #(.S1_W(S1_W), .S2_W(S2_W), .SHIFT(SHIFT), .CNT_W(CNT_W))
  i_see_dual_combiner (.*);

  typedef struct {
    int word; int sel; int unc; int flg; int cnt; string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  int thr_m = 8, cnt_m = 0;
  int last_word = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_thr(input int v);
    @(posedge clk); #2;
    thr_we_i = 1'b1; thr_i = WORD_W'(v);
    @(posedge clk); #2;
    thr_we_i = 1'b0;
    thr_m = v;
  endtask

  // Drives one sample period and pushes the expected result.
  task automatic do_sample(input int a1, input int a2, input int b1, input int b2,
                           input bit ha_mid, input bit hb_mid,
                           input bit ha_end, input bit hb_end, input string tag);
    int wa, wb, d;
    bit fa, fb, big;
    exp_t e;
    @(posedge clk); #2;
    a_hit_i = ha_mid; b_hit_i = hb_mid;
    @(posedge clk); #2;
    a_hit_i = 1'b0; b_hit_i = 1'b0;
    @(posedge clk); #2;
    a_s1_i = S1_W'(a1); a_s2_i = S2_W'(a2);
    b_s1_i = S1_W'(b1); b_s2_i = S2_W'(b2);
    a_hit_i = ha_end; b_hit_i = hb_end;
    sample_i = 1'b1;
    wa = a1 * (1 << SHIFT) + a2;
    wb = b1 * (1 << SHIFT) + b2;
    d  = (wa > wb) ? wa - wb : wb - wa;
    big = d > thr_m;
    fa = ha_mid | ha_end | (a2 == 0) | (a2 == (1 << S2_W) - 1);
    fb = hb_mid | hb_end | (b2 == 0) | (b2 == (1 << S2_W) - 1);
    e.tag = tag;
    e.flg = {30'd0, fb, fa};
    e.unc = 0;
    if (!fa && !fb && !big) begin e.word = wa + wb; e.sel = 0; end
    else if (fa && !fb)     begin e.word = 2 * wb;  e.sel = 2; end
    else if (!fa && fb)     begin e.word = 2 * wa;  e.sel = 1; end
    else                    begin e.word = 2 * wa;  e.sel = 1; e.unc = 1; end
    if ((fa || fb || big) && cnt_m < CMAX) cnt_m++;
    e.cnt = cnt_m;
    last_word = e.word;
    q.push_back(e);
    @(posedge clk); #2;
    sample_i = 1'b0; a_hit_i = 1'b0; b_hit_i = 1'b0;
  endtask

  // Monitor: pops and compares each result as it appears.
  always @(negedge clk) begin
    if (rst_n && out_valid_o) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8: valid without strobe, actual 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " word"}, int'(out_word_o), e.word);
        chk({e.tag, " R5 sel"}, int'(sel_o), e.sel);
        chk({e.tag, " R6 uncorr"}, int'(uncorr_o), e.unc);
        chk({e.tag, " R2 flags"}, int'(flags_o), e.flg);
        chk({e.tag, " R9 count"}, int'(err_cnt_o), e.cnt);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 valid", int'(out_valid_o), 0);
    chk("R10 word", int'(out_word_o), 0);
    chk("R10 count", int'(err_cnt_o), 0);
    chk("R10 flags", int'(flags_o), 0);
    #2 rst_n = 1'b1;

    do_sample(100, 5, 100, 5, 0, 0, 0, 0, "R1 R4 equal");
    do_sample(100, 5, 100, 13, 0, 0, 0, 0, "R7 R4 diff at default");
    do_sample(100, 5, 100, 14, 0, 0, 0, 0, "R7 R6 diff over default");
    do_sample(50, 0, 60, 9, 0, 0, 0, 0, "R2 A low rail");
    do_sample(60, 10, 60, 127, 0, 0, 0, 0, "R2 B high rail");
    do_sample(200, 20, 200, 21, 1, 0, 0, 0, "R3 A mid hit");
    do_sample(7, 3, 7, 3, 0, 0, 0, 1, "R3 B strobe hit");
    do_sample(7, 3, 7, 3, 0, 0, 0, 0, "R3 hit cleared");
    // R8: outputs hold between strobes
    repeat (4) @(negedge clk);
    chk("R8 hold word", int'(out_word_o), last_word);
    chk("R8 valid low", int'(out_valid_o), 0);
    do_sample(300, 30, 300, 0, 1, 0, 0, 0, "R6 both flagged");
    do_sample(511, 126, 511, 126, 0, 0, 0, 0, "R1 full scale");
    set_thr(3);
    do_sample(10, 4, 10, 7, 0, 0, 0, 0, "R7 diff at loaded");
    do_sample(10, 4, 10, 8, 0, 0, 0, 0, "R7 diff over loaded");
    do_sample(10, 127, 10, 4, 0, 0, 0, 0, "R9 saturate");
    do_sample(20, 9, 20, 1, 0, 0, 0, 0, "R9 R6 past max");
    repeat (4) @(posedge clk);
    chk("R8 queue drained", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule